// File: doc/BRIEF.md
# Per-Core Local Tick Timer

This block gives one processor core a private source of timer interrupts. It has two counting stages in a chain. The first stage is a prescaler: it divides the input clock by a programmable value plus one and emits a single-cycle tick. The second stage counts these ticks down from a 31-bit reload value. When the count runs out, the second stage sets a sticky interrupt status bit. The interrupt output is that status bit gated by an enable bit.

Software works through a small word-addressed register port. Writes to the prescale buffer, the reload buffer and the control word do not act at once. Each one takes effect a fixed number of clocks later, set by a parameter. When it takes effect, a per-register acknowledge bit is set, and software clears that bit by writing 1 to it. A write to the reload buffer takes effect only if its top bit is 1. The control word has three bits: a run bit for the prescaler, a run bit for the tick counter, and a mode bit. The mode bit selects between auto-reload (interval) operation and single-shot operation.

Top module: `lt_tick_timer`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low.
- R2: A write to word 0 (prescale), word 1 (reload) or word 2 (control) becomes visible on readback exactly WR_LAT clocks after the write is sampled. In the same clock, write-status bit 0, bit 1 or bit 3 respectively is set. Write status is read at word 5.
- R3: A write-status bit is cleared only by writing 1 to that bit position at word 5. Writing 0 leaves the bit unchanged.
- R4: With a prescale value N, the prescaler ticks once every N+1 clocks, counting from the clock in which its run bit rises.
- R5: With a reload value M and the control word bit 0 (prescaler run) and bit 1 (counter run) both rising together, the status bit (word 3, bit 0) sets M·(N+1) clocks after the control write takes effect.
- R6: A reload-buffer write with bit 31 clear is ignored: the buffer reads back unchanged. A write with bit 31 set loads bits 30:0 into both the buffer and the running counter.
- R7: With control bit 2 set (interval mode), the counter reloads on expiry with no software action. The status bit then sets again every M·(N+1) clocks.
- R8: With control bit 2 clear, the counter stops at zero after one expiry and raises no further interrupt.
- R9: The status bit is sticky. Writing 1 to word 3 bit 0 clears it, and writing 0 does not. `irq_o` is high exactly when both the status bit and the enable bit (word 4, bit 0) are set.
- R10: Clearing a run bit freezes its counter. Setting the bit again reloads that counter from its buffer, so a full period is counted again.
- R11: While control bit 0 is clear, no ticks are produced and the tick counter does not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word index for both read and write |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Interrupt request (status AND enable) |

## Verification
The bench sweeps prescale values 0 to 3 against reload values 1 to 4 in interval mode. For each pair it checks the clock count to the first interrupt, which covers the write latency plus the product M·(N+1), and then the count to the second interrupt. A wrong tick period, an off-by-one expiry or a missing reload each give a different count. Single-shot runs check that the counter stays silent after one expiry. Stop-and-restart runs tell a reload from the buffer apart from a resumed remainder. A run with the prescaler stopped shows that the tick counter holds its count. Readback at WR_LAT−1 and at WR_LAT clocks after a write pins the apply latency and the acknowledge bits. It also shows that a reload write without bit 31 is dropped.

// File: rtl/lt_pkg.sv
`timescale 1ns/1ps
package lt_pkg;

  localparam int REG_AW = 3;

  // Word index of each register on the port.
  typedef enum logic [REG_AW-1:0] {
    RA_TICK  = 3'd0,
    RA_ICNT  = 3'd1,
    RA_CTRL  = 3'd2,
    RA_ISTAT = 3'd3,
    RA_IEN   = 3'd4,
    RA_WSTAT = 3'd5
  } reg_addr_e;

  // Control word, bit 0 at the bottom.
  typedef struct packed {
    logic interval;   // bit 2
    logic intr_run;   // bit 1
    logic tick_run;   // bit 0
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/lt_wr_sync.sv
`timescale 1ns/1ps
// Holds one register write and releases it LAT clocks later.
module lt_wr_sync #(
  parameter int DW  = 32,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [DW-1:0] data_i,
  output logic          apply_o,
  output logic [DW-1:0] data_o
);

  logic          pend_q, pend_d;
  logic [DW-1:0] dat_q, dat_d;
  logic          last;

  generate
    if (LAT > 1) begin : g_count
      localparam int CW = $clog2(LAT);
      logic [CW-1:0] cnt_q, cnt_d;

      always_comb begin
        cnt_d = cnt_q;
        if (wr_i)                        cnt_d = CW'(LAT - 1);
        else if (pend_q && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign last = (cnt_q == '0);
    end else begin : g_direct
      assign last = 1'b1;
    end
  endgenerate

  // A fresh write restarts the wait and replaces the held value.
  assign apply_o = pend_q && last && !wr_i;

  always_comb begin
    pend_d = pend_q;
    dat_d  = dat_q;
    if (wr_i) begin
      pend_d = 1'b1;
      dat_d  = data_i;
    end else if (apply_o) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      dat_q  <= '0;
    end else begin
      pend_q <= pend_d;
      if (wr_i) dat_q <= dat_d;
    end
  end

  assign data_o = dat_q;

  p_pend_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> pend_q);

endmodule

// File: rtl/lt_prescaler.sv
`timescale 1ns/1ps
// First stage: one tick every buf_i+1 clocks while running.
module lt_prescaler #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          start_i,
  input  logic [TW-1:0] buf_i,
  output logic          tick_o
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign tick_o = run_i && !start_i && (cnt_q == '0);
  assign cnt_en = start_i || run_i;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)          cnt_d = buf_i;
    else if (tick_o)      cnt_d = buf_i;
    else if (run_i)       cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  p_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !start_i) |=> $stable(cnt_q));

endmodule

// File: rtl/lt_intr_counter.sv
`timescale 1ns/1ps
// Second stage: counts ticks down and flags expiry.
module lt_intr_counter #(
  parameter int CW = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          start_i,
  input  logic          tick_i,
  input  logic          interval_i,
  input  logic          upd_i,
  input  logic [CW-1:0] upd_val_i,
  output logic [CW-1:0] buf_o,
  output logic          expire_o
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] buf_q, buf_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          step;

  assign step     = run_i && tick_i && !upd_i && !start_i && (cnt_q != '0);
  assign expire_o = step && (cnt_q == ONE);

  always_comb begin
    buf_d = upd_i ? upd_val_i : buf_q;
    cnt_d = cnt_q;
    if (upd_i)           cnt_d = upd_val_i;
    else if (start_i)    cnt_d = buf_q;
    else if (expire_o)   cnt_d = interval_i ? buf_q : '0;
    else if (step)       cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      cnt_q <= '0;
    end else begin
      if (upd_i)                           buf_q <= buf_d;
      if (upd_i || start_i || step)        cnt_q <= cnt_d;
    end
  end

  assign buf_o = buf_q;

  p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !start_i && !upd_i) |=> $stable(cnt_q));

  p_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !interval_i) |=> (cnt_q == '0));

  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && interval_i) |=> (cnt_q == $past(buf_q)));

endmodule

// File: rtl/lt_tick_timer.sv
`timescale 1ns/1ps
module lt_tick_timer
  import lt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TICK_W = 32,
  parameter int WR_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);

  localparam int ICNT_W = DATA_W - 1;

  // Write decode
  logic wr_tick, wr_icnt, wr_ctrl, wr_ist, wr_ien, wr_ws;
  assign wr_tick = reg_wr_i && (reg_addr_i == RA_TICK);
  assign wr_icnt = reg_wr_i && (reg_addr_i == RA_ICNT);
  assign wr_ctrl = reg_wr_i && (reg_addr_i == RA_CTRL);
  assign wr_ist  = reg_wr_i && (reg_addr_i == RA_ISTAT);
  assign wr_ien  = reg_wr_i && (reg_addr_i == RA_IEN);
  assign wr_ws   = reg_wr_i && (reg_addr_i == RA_WSTAT);

  // Delayed-apply paths
  logic              ap_tick, ap_icnt, ap_ctrl;
  logic [TICK_W-1:0] tick_new;
  logic [DATA_W-1:0] icnt_raw;
  logic [CTRL_W-1:0] ctrl_raw;

  lt_wr_sync #(.DW(TICK_W), .LAT(WR_LAT)) u_sync_tick (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_tick),
    .data_i(reg_wdata_i[TICK_W-1:0]), .apply_o(ap_tick), .data_o(tick_new));

  lt_wr_sync #(.DW(DATA_W), .LAT(WR_LAT)) u_sync_icnt (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_icnt),
    .data_i(reg_wdata_i), .apply_o(ap_icnt), .data_o(icnt_raw));

  lt_wr_sync #(.DW(CTRL_W), .LAT(WR_LAT)) u_sync_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_ctrl),
    .data_i(reg_wdata_i[CTRL_W-1:0]), .apply_o(ap_ctrl), .data_o(ctrl_raw));

  // Architectural registers
  logic [TICK_W-1:0] tick_buf_q, tick_buf_d;
  ctrl_t             ctrl_q, ctrl_d, ctrl_new;
  logic              ist_q, ist_d;
  logic              ien_q, ien_d;
  logic [2:0]        ws_q, ws_d, ws_set, ws_clr;   // {ctrl, reload, prescale}

  logic tick_start, intr_start, icnt_upd;
  logic tick, expire;
  logic [ICNT_W-1:0] icnt_buf;

  assign ctrl_new   = ctrl_t'(ctrl_raw);
  assign tick_start = ap_ctrl && ctrl_new.tick_run && !ctrl_q.tick_run;
  assign intr_start = ap_ctrl && ctrl_new.intr_run && !ctrl_q.intr_run;
  assign icnt_upd   = ap_icnt && icnt_raw[DATA_W-1];

  lt_prescaler #(.TW(TICK_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run_i(ctrl_q.tick_run), .start_i(tick_start),
    .buf_i(tick_buf_q), .tick_o(tick));

  lt_intr_counter #(.CW(ICNT_W)) u_icnt (
    .clk(clk), .rst_n(rst_n), .run_i(ctrl_q.intr_run), .start_i(intr_start),
    .tick_i(tick), .interval_i(ctrl_q.interval), .upd_i(icnt_upd),
    .upd_val_i(icnt_raw[ICNT_W-1:0]), .buf_o(icnt_buf), .expire_o(expire));

  // Next-state
  always_comb begin
    tick_buf_d = ap_tick ? tick_new : tick_buf_q;
    ctrl_d     = ap_ctrl ? ctrl_new : ctrl_q;
    ist_d      = expire | (ist_q & ~(wr_ist & reg_wdata_i[0]));
    ien_d      = wr_ien ? reg_wdata_i[0] : ien_q;
    ws_set     = {ap_ctrl, ap_icnt, ap_tick};
    ws_clr     = wr_ws ? {reg_wdata_i[3], reg_wdata_i[1], reg_wdata_i[0]} : 3'b000;
    ws_d       = ws_set | (ws_q & ~ws_clr);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_buf_q <= '0;
      ctrl_q     <= '0;
      ist_q      <= 1'b0;
      ien_q      <= 1'b0;
      ws_q       <= '0;
    end else begin
      if (ap_tick)            tick_buf_q <= tick_buf_d;
      if (ap_ctrl)            ctrl_q     <= ctrl_d;
      if (expire || wr_ist)   ist_q      <= ist_d;
      if (wr_ien)             ien_q      <= ien_d;
      if (wr_ws || (|ws_set)) ws_q       <= ws_d;
    end
  end

  assign irq_o = ist_q & ien_q;

  // Read mux
  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_e'(reg_addr_i))
      RA_TICK:  reg_rdata_o = DATA_W'(tick_buf_q);
      RA_ICNT:  reg_rdata_o = DATA_W'(icnt_buf);
      RA_CTRL:  reg_rdata_o = DATA_W'(ctrl_q);
      RA_ISTAT: reg_rdata_o = DATA_W'(ist_q);
      RA_IEN:   reg_rdata_o = DATA_W'(ien_q);
      RA_WSTAT: reg_rdata_o = DATA_W'({ws_q[2], 1'b0, ws_q[1:0]});
      default:  reg_rdata_o = '0;
    endcase
  end

  p_ws_after_apply_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ap_ctrl |=> ws_q[2]);

  p_ws_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ws_q[0] && !wr_ws) |=> ws_q[0]);

  p_status_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ist_q && !wr_ist) |=> ist_q);

  p_no_tick_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.tick_run |-> !tick);

endmodule

// File: tb/test_lt_tick_timer.sv
`timescale 1ns/1ps
module test_lt_tick_timer;

  localparam int WR_LAT = 3;
  localparam logic [31:0] UPD = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lt_tick_timer #(.DATA_W(32), .TICK_W(32), .WR_LAT(WR_LAT)) i_lt_tick_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq));

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive at a negedge; returns one negedge later (write edge passed).
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic settle();
    repeat (WR_LAT + 1) @(negedge clk);
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic quiet(input int cyc, output int seen);
    seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (irq) seen = 1;
    end
  endtask

  task automatic prep(input int n_tick, input int m_icnt);
    wr(3'd2, 32'd0);
    settle();
    wr(3'd0, 32'(n_tick));
    wr(3'd1, UPD | 32'(m_icnt));
    wr(3'd3, 32'd1);
    wr(3'd4, 32'd1);
    settle();
  endtask

  initial begin
    logic [31:0] v;
    int n, seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk($sformatf("R1 reg%0d", a), v, 0);
    end
    chk("R1 irq", irq, 0);

    // R2: apply latency and write-status bits
    wr(3'd0, 32'h5A);
    repeat (WR_LAT - 1) @(negedge clk);
    rd(3'd0, v); chk("R2 prescale before latency", v, 0);
    rd(3'd5, v); chk("R2 ws before latency", v, 0);
    @(negedge clk);
    rd(3'd0, v); chk("R2 prescale at latency", v, 32'h5A);
    rd(3'd5, v); chk("R2 ws bit0", v, 1);
    // R3: write-1-to-clear
    wr(3'd5, 32'd0);
    rd(3'd5, v); chk("R3 ws write0 keeps", v, 1);
    wr(3'd5, 32'd1);
    rd(3'd5, v); chk("R3 ws write1 clears", v, 0);
    wr(3'd2, 32'd0); settle();
    rd(3'd5, v); chk("R2 ws bit3 on control", v, 8);
    wr(3'd5, 32'd8);

    // R6: reload write without bit 31 ignored
    wr(3'd1, UPD | 32'd2); settle();
    rd(3'd5, v); chk("R2 ws bit1 on reload", v, 2);
    wr(3'd5, 32'd2);
    wr(3'd1, 32'h55); settle();
    rd(3'd1, v); chk("R6 reload without bit31 ignored", v, 2);
    wr(3'd1, UPD | 32'h55); settle();
    rd(3'd1, v); chk("R6 reload with bit31 loads", v, 32'h55);

    // R4 R5 R7: sweep prescale x reload in interval mode
    for (int nt = 0; nt < 4; nt++) begin
      for (int mc = 1; mc < 5; mc++) begin
        int p;
        p = mc * (nt + 1);
        prep(nt, mc);
        wr(3'd2, 32'd7);
        wait_irq(n);
        chk($sformatf("%s first N=%0d M=%0d", (mc == 1) ? "R4" : "R5", nt, mc),
            n, WR_LAT + p);
        if (p >= 2) begin
          reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 32'd1;
          @(negedge clk);
          reg_wr = 1'b0; reg_wdata = '0;
          n = 1;
          while (!irq && n < 1000) begin
            @(negedge clk);
            n++;
          end
          chk($sformatf("R7 second N=%0d M=%0d", nt, mc), n, p);
        end
      end
    end

    // R8: single shot
    prep(1, 3);
    wr(3'd2, 32'd3);
    wait_irq(n);
    chk("R5 single-shot first expiry", n, WR_LAT + 6);
    wr(3'd3, 32'd1);
    quiet(40, seen);
    chk("R8 no second expiry", seen, 0);
    // R10: restart reloads
    wr(3'd2, 32'd0); settle();
    wr(3'd2, 32'd3);
    wait_irq(n);
    chk("R10 restart after single-shot", n, WR_LAT + 6);

    // R10: freeze mid-count, then restart counts a full period
    prep(1, 8);
    wr(3'd2, 32'd7);
    repeat (6) @(negedge clk);
    wr(3'd2, 32'd4);
    quiet(30, seen);
    chk("R10 frozen no expiry", seen, 0);
    wr(3'd2, 32'd7);
    wait_irq(n);
    chk("R10 full period after restart", n, WR_LAT + 16);

    // R11: prescaler stopped holds the tick counter
    prep(1, 3);
    wr(3'd2, 32'd6);
    quiet(40, seen);
    chk("R11 no ticks while prescaler off", seen, 0);
    wr(3'd2, 32'd7);
    wait_irq(n);
    chk("R11 counter unchanged while off", n, WR_LAT + 6);

    // R9: enable gating and sticky status
    wr(3'd2, 32'd0); settle();
    wr(3'd4, 32'd0);
    wr(3'd3, 32'd1);
    wr(3'd0, 32'd0);
    wr(3'd1, UPD | 32'd2); settle();
    wr(3'd2, 32'd3);
    repeat (WR_LAT + 4) @(negedge clk);
    chk("R9 irq masked", irq, 0);
    rd(3'd3, v); chk("R9 status set while masked", v, 1);
    wr(3'd4, 32'd1);
    chk("R9 irq after enable", irq, 1);
    wr(3'd3, 32'd0);
    chk("R9 write0 keeps status", irq, 1);
    wr(3'd3, 32'd1);
    chk("R9 write1 clears status", irq, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule